// File: doc/BRIEF.md
# Synchronous Serial Clock-Stretch Controller

This block is the peripheral end of a two-wire synchronous serial link with one clock line and one data line, both open-drain. Once enabled, the block can hold the clock line low right after the remote party drives it low. This stalls the transfer until software has dealt with the current bit. The hold is applied either on every falling clock edge or only when receive condition 1 has been flagged. Software ends the hold by writing the data buffer register. The same write sets the level that the block places on the data line.

Receive condition 1 and condition 2 are decoded outside the block and arrive as single-cycle strobes. Each strobe sets a sticky flag. Software can poll the flag, and the flag can raise an interrupt when its mask bit is set. Both line inputs pass through a synchronizer before the block uses them. Software reaches the block through a small synchronous register bus whose read data is registered.

Register map. Reads and writes use `bus_addr_i`.
- Address 0, control:
  - bit0: link enable.
  - bit1: stretch on every fall.
  - bit2: stretch on condition 1 only.
  - bit3: wait status, read only.
  - bit4: condition-1 interrupt mask.
  - bit5: condition-2 interrupt mask.
- Address 1, data buffer: bit0 is the data-line level (1 releases the line, 0 pulls it low). Reads return bit1 as the synchronized data line.
- Address 2: bit0 is the condition-1 flag.
- Address 3: bit0 is the condition-2 flag.

Top module: `sclk_stretch_ctrl`

## Requirements
- R1: While the link enable (control bit0) is 0, neither `clk_line_oe_o` nor `dat_line_oe_o` is asserted.
- R2: With control bit0 and bit1 set, a high-to-low change on `clk_line_i` makes `clk_line_oe_o` assert after the third rising clock edge. It then stays asserted until a release event.
- R3: Control bit3 reads 1 exactly while the clock line is being held and the link is enabled.
- R4: A write to address 1 clears the hold at the edge on which the write is taken. The wait status is clear afterwards.
- R5: With control bit2 set and bit1 clear, a falling edge starts a hold only if the condition-1 flag is set or a condition-1 strobe arrives in the same cycle.
- R6: A strobe on `cond1_det_i` or `cond2_det_i` sets the flag at address 2 or 3 (bit0). The flag stays set until that address is read. If a strobe and a read coincide, the flag stays set.
- R7: `irq_o` is high when the condition-1 flag and control bit4 are both set, or when the condition-2 flag and control bit5 are both set.
- R8: If a data-buffer write and a detected falling edge fall on the same cycle, the write wins and no hold starts. The next hold needs the next falling edge.
- R9: Writing 0 to control bit0 deasserts `clk_line_oe_o` at the edge taking the write and ends the hold.
- R10: `dat_line_oe_o` equals link enable AND NOT buffer bit0. Reset leaves buffer bit0 at 1. A read of address 1 returns bit1 as the synchronized data line.
- R11: `bus_rdata_o` updates only on the edge after a cycle with `bus_re_i` high, showing the state before that edge. It is zero after reset and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_line_i | input | 1 | Level seen on the serial clock line |
| dat_line_i | input | 1 | Level seen on the serial data line |
| clk_line_oe_o | output | 1 | Pull the clock line low when 1 |
| dat_line_oe_o | output | 1 | Pull the data line low when 1 |
| cond1_det_i | input | 1 | Receive condition 1 strobe |
| cond2_det_i | input | 1 | Receive condition 2 strobe |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Masked condition interrupt |

## Verification
A stale hold state shows up on `clk_line_oe_o` one cycle after the write or fall that should have changed it. The bench's own model predicts that output on every clock, so the mismatch is caught at once. A wrong synchronizer depth moves the start of a hold by one or more cycles against the three-edge latency, and the per-cycle comparison catches that too. A flag that is not sticky, or one that clears at the wrong time, shows on `irq_o` in the next cycle and in the next read of address 2 or 3.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_BUF   = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG1 = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAG2 = 2'd3;

  localparam int B_EN    = 0;
  localparam int B_ALL   = 1;
  localparam int B_COND  = 2;
  localparam int B_WAIT  = 3;
  localparam int B_MASK1 = 4;
  localparam int B_MASK2 = 5;

  typedef enum logic {ST_FREE = 1'b0, ST_HOLD = 1'b1} hold_state_e;
endpackage

// File: rtl/sst_rst_sync.sv
module sst_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= 2'b00;
    else         pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_sync_no = pipe_q[1];
endmodule

// File: rtl/sst_line_sync.sv
module sst_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] fall_o
);
  localparam int TOP = STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q, prev_d;

    always_comb begin
      if (STAGES > 1) chain_d = {chain_q[STAGES-2:0], line_i[g]};
      else            chain_d = line_i[g];
      prev_d = chain_q[TOP];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= chain_d;
        prev_q  <= prev_d;
      end
    end

    assign sync_o[g] = chain_q[TOP];
    assign fall_o[g] = prev_q & ~chain_q[TOP];
  end
endmodule

// File: rtl/sst_hold_fsm.sv
module sst_hold_fsm
  import sst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic all_en_i,
  input  logic cond_en_i,
  input  logic cond1_flag_i,
  input  logic cond1_det_i,
  input  logic fall_i,
  input  logic buf_wr_i,
  output logic hold_o
);
  hold_state_e state_q, state_d;
  logic        start;

  always_comb begin
    start   = fall_i & (all_en_i | (cond_en_i & (cond1_flag_i | cond1_det_i)));
    state_d = state_q;
    if (!en_i)          state_d = ST_FREE;
    else if (buf_wr_i)  state_d = ST_FREE;
    else if (start)     state_d = ST_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FREE;
    else         state_q <= state_d;
  end

  assign hold_o = (state_q == ST_HOLD);

  // R4
  buf_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_i |=> !hold_o);

  // R9
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !hold_o);

  // R2
  fall_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(fall_i));
endmodule

// File: rtl/sst_reg_bank.sv
module sst_reg_bank
  import sst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cond1_det_i,
  input  logic              cond2_det_i,
  input  logic              hold_i,
  input  logic              dat_sync_i,
  output logic              en_o,
  output logic              all_en_o,
  output logic              cond_en_o,
  output logic              buf_bit_o,
  output logic              buf_wr_o,
  output logic              cond1_flag_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              en_q, en_d, all_q, all_d, cen_q, cen_d;
  logic [1:0]        mask_q, mask_d;
  logic              buf_q, buf_d;
  logic              c1_q, c1_d, c2_q, c2_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_mux;
  logic              ctrl_wr;

  always_comb begin
    ctrl_wr  = we_i && (addr_i == A_CTRL);
    buf_wr_o = we_i && (addr_i == A_BUF);

    en_d   = ctrl_wr ? wdata_i[B_EN]   : en_q;
    all_d  = ctrl_wr ? wdata_i[B_ALL]  : all_q;
    cen_d  = ctrl_wr ? wdata_i[B_COND] : cen_q;
    mask_d = ctrl_wr ? {wdata_i[B_MASK2], wdata_i[B_MASK1]} : mask_q;
    buf_d  = buf_wr_o ? wdata_i[0] : buf_q;

    c1_d = cond1_det_i | (c1_q & ~(re_i && (addr_i == A_FLAG1)));
    c2_d = cond2_det_i | (c2_q & ~(re_i && (addr_i == A_FLAG2)));

    rd_mux = '0;
    unique case (addr_i)
      A_CTRL: begin
        rd_mux[B_EN]    = en_q;
        rd_mux[B_ALL]   = all_q;
        rd_mux[B_COND]  = cen_q;
        rd_mux[B_WAIT]  = hold_i & en_q;
        rd_mux[B_MASK1] = mask_q[0];
        rd_mux[B_MASK2] = mask_q[1];
      end
      A_BUF: begin
        rd_mux[0] = buf_q;
        rd_mux[1] = dat_sync_i;
      end
      A_FLAG1: rd_mux[0] = c1_q;
      default: rd_mux[0] = c2_q;
    endcase
    rdata_d = re_i ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      all_q   <= 1'b0;
      cen_q   <= 1'b0;
      mask_q  <= 2'b00;
      buf_q   <= 1'b1;
      c1_q    <= 1'b0;
      c2_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      all_q   <= all_d;
      cen_q   <= cen_d;
      mask_q  <= mask_d;
      buf_q   <= buf_d;
      c1_q    <= c1_d;
      c2_q    <= c2_d;
      rdata_q <= rdata_d;
    end
  end

  assign en_o         = en_q;
  assign all_en_o     = all_q;
  assign cond_en_o    = cen_q;
  assign buf_bit_o    = buf_q;
  assign cond1_flag_o = c1_q;
  assign rdata_o      = rdata_q;
  assign irq_o        = (c1_q & mask_q[0]) | (c2_q & mask_q[1]);

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond1_det_i |=> cond1_flag_o);

  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/sclk_stretch_ctrl.sv
module sclk_stretch_ctrl
  import sst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_line_i,
  input  logic              dat_line_i,
  output logic              clk_line_oe_o,
  output logic              dat_line_oe_o,
  input  logic              cond1_det_i,
  input  logic              cond2_det_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic       rst_n_s;
  logic [1:0] sync, fall;
  logic       en, all_en, cond_en, buf_bit, buf_wr, c1_flag, hold;

  sst_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  sst_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .line_i ({dat_line_i, clk_line_i}),
    .sync_o (sync),
    .fall_o (fall)
  );

  sst_reg_bank u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .addr_i       (bus_addr_i),
    .we_i         (bus_we_i),
    .re_i         (bus_re_i),
    .wdata_i      (bus_wdata_i),
    .cond1_det_i  (cond1_det_i),
    .cond2_det_i  (cond2_det_i),
    .hold_i       (hold),
    .dat_sync_i   (sync[1]),
    .en_o         (en),
    .all_en_o     (all_en),
    .cond_en_o    (cond_en),
    .buf_bit_o    (buf_bit),
    .buf_wr_o     (buf_wr),
    .cond1_flag_o (c1_flag),
    .irq_o        (irq_o),
    .rdata_o      (bus_rdata_o)
  );

  sst_hold_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .en_i         (en),
    .all_en_i     (all_en),
    .cond_en_i    (cond_en),
    .cond1_flag_i (c1_flag),
    .cond1_det_i  (cond1_det_i),
    .fall_i       (fall[0]),
    .buf_wr_i     (buf_wr),
    .hold_o       (hold)
  );

  assign clk_line_oe_o = hold & en;
  assign dat_line_oe_o = en & ~buf_bit;

  // R1
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !en |-> (!clk_line_oe_o && !dat_line_oe_o));
endmodule

// File: tb/sclk_stretch_ctrl_tb_top.sv
module sclk_stretch_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       remote_clk = 1'b1, remote_dat = 1'b1;
  logic       cond1 = 1'b0, cond2 = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] wdata = 8'd0;
  wire        clk_oe, dat_oe, irq;
  wire  [7:0] rdata;
  wire        clk_line = remote_clk & ~clk_oe;
  wire        dat_line = remote_dat & ~dat_oe;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sclk_stretch_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_line_i(clk_line), .dat_line_i(dat_line),
    .clk_line_oe_o(clk_oe), .dat_line_oe_o(dat_oe),
    .cond1_det_i(cond1), .cond2_det_i(cond2),
    .bus_addr_i(addr), .bus_we_i(we), .bus_re_i(re), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  bit m_en, m_all, m_cen, m_hold, m_buf, m_c1, m_c2;
  bit [1:0] m_mask;
  bit [7:0] m_rd;
  bit ch[$], dh[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_all = 0; m_cen = 0; m_hold = 0; m_buf = 1;
      m_c1 = 0; m_c2 = 0; m_mask = 0; m_rd = 0;
      ch = '{1, 1, 1}; dh = '{1, 1, 1};
    end else begin
      bit fell, go, bw;
      bit [7:0] v;
      fell = ch[2] && !ch[1];
      go   = fell && (m_all || (m_cen && (m_c1 || cond1)));
      bw   = we && addr == 2'd1;
      if (re) begin
        v = 0;
        case (addr)
          2'd0: v = {2'b00, m_mask[1], m_mask[0], m_hold && m_en, m_cen, m_all, m_en};
          2'd1: v = {6'd0, dh[1], m_buf};
          2'd2: v = {7'd0, m_c1};
          default: v = {7'd0, m_c2};
        endcase
        m_rd = v;
      end
      if (!m_en || bw) m_hold = 0;
      else if (go) m_hold = 1;
      m_c1 = cond1 || (m_c1 && !(re && addr == 2'd2));
      m_c2 = cond2 || (m_c2 && !(re && addr == 2'd3));
      if (we && addr == 2'd0) begin
        m_en = wdata[0]; m_all = wdata[1]; m_cen = wdata[2];
        m_mask = wdata[5:4];
      end
      if (bw) m_buf = wdata[0];
      ch.push_front(clk_line); void'(ch.pop_back());
      dh.push_front(dat_line); void'(dh.pop_back());
    end
  end

  // every-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #1;
    n_cmp++;
    if (clk_oe !== (m_hold && m_en)) begin
      n_bad++;
      $display("FAIL R2/R4/R9 clk_line_oe act=%b exp=%b t=%0t", clk_oe, m_hold && m_en, $time);
    end
    n_cmp++;
    if (dat_oe !== (m_en && !m_buf)) begin
      n_bad++;
      $display("FAIL R10 dat_line_oe act=%b exp=%b t=%0t", dat_oe, m_en && !m_buf, $time);
    end
    n_cmp++;
    if (irq !== ((m_c1 && m_mask[0]) || (m_c2 && m_mask[1]))) begin
      n_bad++;
      $display("FAIL R7 irq act=%b exp=%b t=%0t", irq, (m_c1 && m_mask[0]) || (m_c2 && m_mask[1]), $time);
    end
    n_cmp++;
    if (rdata !== m_rd) begin
      n_bad++;
      $display("FAIL R11 rdata act=%h exp=%h t=%0t", rdata, m_rd, $time);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1;
    @(negedge clk); re = 0; d = rdata;
  endtask

  initial begin
    logic [7:0] d;
    idle(5); rst_n = 1; idle(4);

    chk("R11 reset rdata", rdata, 8'h00);
    chk("R1 reset clk oe", {7'd0, clk_oe}, 8'h00);
    rd(2'd1, d); chk("R10 reset buffer read", d, 8'h03);

    // R1: disabled, falls cause nothing
    remote_clk = 0; idle(5);
    chk("R1 no hold while disabled", {7'd0, clk_oe}, 8'h00);
    remote_clk = 1; idle(4);

    // R2/R3: unconditional stretch, three-edge latency
    wr(2'd0, 8'h03); idle(3);
    @(negedge clk); remote_clk = 0;
    @(negedge clk); @(negedge clk);
    chk("R2 not yet held", {7'd0, clk_oe}, 8'h00);
    @(negedge clk);
    chk("R2 held after third edge", {7'd0, clk_oe}, 8'h01);
    remote_clk = 1; idle(6);
    chk("R2 still held", {7'd0, clk_oe}, 8'h01);
    rd(2'd0, d); chk("R3 wait status", d, 8'h0B);

    // R4/R10: buffer write releases, drives data low
    wr(2'd1, 8'h00);
    chk("R4 released", {7'd0, clk_oe}, 8'h00);
    chk("R10 data pulled", {7'd0, dat_oe}, 8'h01);
    rd(2'd0, d); chk("R4 wait cleared", d, 8'h03);
    rd(2'd1, d); chk("R10 buffer read", d, 8'h00);
    wr(2'd1, 8'h01); idle(3);

    // R8: buffer writes across the fall edge
    @(negedge clk); remote_clk = 0;
    addr = 2'd1; wdata = 8'h01; we = 1;
    idle(6); we = 0; idle(3);
    chk("R8 release wins", {7'd0, clk_oe}, 8'h00);
    remote_clk = 1; idle(4);

    // R5: conditional stretch
    wr(2'd0, 8'h05); idle(3);
    remote_clk = 0; idle(6);
    chk("R5 no condition no hold", {7'd0, clk_oe}, 8'h00);
    remote_clk = 1; idle(4);
    @(negedge clk); cond1 = 1; @(negedge clk); cond1 = 0;
    remote_clk = 0; idle(6);
    chk("R5 hold on condition", {7'd0, clk_oe}, 8'h01);
    remote_clk = 1;

    // R9: disable while holding
    wr(2'd0, 8'h00);
    chk("R9 disable releases", {7'd0, clk_oe}, 8'h00);
    chk("R1 data released", {7'd0, dat_oe}, 8'h00);

    // R6/R7: flags and interrupt
    wr(2'd0, 8'h31);
    chk("R7 irq from cond1", {7'd0, irq}, 8'h01);
    rd(2'd2, d); chk("R6 flag1 read", d, 8'h01);
    rd(2'd2, d); chk("R6 flag1 cleared", d, 8'h00);
    chk("R7 irq low", {7'd0, irq}, 8'h00);
    @(negedge clk); cond2 = 1; @(negedge clk); cond2 = 0;
    chk("R7 irq from cond2", {7'd0, irq}, 8'h01);
    @(negedge clk); addr = 2'd3; re = 1; cond2 = 1;
    @(negedge clk); re = 0; cond2 = 0;
    chk("R6 set wins over read", rdata, 8'h01);
    rd(2'd3, d); chk("R6 flag2 still set", d, 8'h01);
    wr(2'd0, 8'h01);
    @(negedge clk); cond1 = 1; @(negedge clk); cond1 = 0;
    chk("R7 masked", {7'd0, irq}, 8'h00);
    rd(2'd2, d);

    // mixed stimulus against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      we = 0; re = 0; cond1 = 0; cond2 = 0;
      if (r < 12) remote_clk = ~remote_clk;
      else if (r < 18) remote_dat = ~remote_dat;
      else if (r < 22) cond1 = 1;
      else if (r < 25) cond2 = 1;
      else if (r < 29) begin addr = 2'd1; wdata = 8'($urandom); we = 1; end
      else if (r < 31) begin addr = 2'd0; wdata = 8'($urandom) | 8'h01; we = 1; end
      else if (r < 32) begin addr = 2'd0; wdata = 8'h00; we = 1; end
      else if (r < 42) begin addr = 2'($urandom); re = 1; end
    end
    @(negedge clk); we = 0; re = 0; cond1 = 0; cond2 = 0;
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule